// File: doc/BRIEF.md
# Valley Overcurrent and Hiccup Controller

This block supervises one phase of a buck converter against overcurrent. While the low-side switch conducts, the block watches a digital flag from a valley-current comparator. When that conduction interval ends, the block decides whether the next high-side turn-on is allowed. Any overcurrent seen during the interval blocks the next turn-on. The block also keeps a count of how many intervals in a row have shown overcurrent.

The protection trips in two cases. The first is a run of 31 overcurrent intervals in a row. The second is an overcurrent interval that closes while the output undervoltage flag is raised, which trips at once. A configuration bit chooses what happens after a trip. In latch mode the converter is held off until the enable input goes low and returns, or until reset. In hiccup mode the converter is held off for a timed wait and is then asked to restart. The wait is either a programmable number of 4 ms steps or a fixed 16 ms.

A sticky fault flag records every trip. The 5-bit current-limit code is not used by the block: it only passes it to the analog comparator, at 1.5 A per LSB. The register that holds this code elsewhere resets to 10100b, which is 30 A.

Top module: `valley_ocp_ctrl`

## Requirements
- R1: After a low-side interval in which `oc_flag_i` was high on at least one cycle while `ls_on_i` was high, `hs_en_o` is low from the cycle after `ls_on_i` falls. After a clean interval it is high again.
- R2: The 31st overcurrent interval in a row raises `shutdown_o` in the cycle after `ls_on_i` falls. After 30 such intervals it stays low.
- R3: A clean interval clears the run, so the count starts again from zero: 30 overcurrent intervals, then one clean interval, then 30 more, cause no trip.
- R4: An overcurrent interval that closes while `uv_flag_i` is high trips at once. A clean interval that closes with `uv_flag_i` high does not trip.
- R5: With `resp_hiccup_i`=0, a trip holds `shutdown_o` high and `hs_en_o` low indefinitely. No `restart_o` pulse is issued, and low-side intervals are ignored.
- R6: A latched trip is released only by `enable_i` going low. While `enable_i` is low, `hs_en_o` is low. Once it returns high, `shutdown_o` is low and `hs_en_o` is high again.
- R7: With `resp_hiccup_i`=1 and `hic_prog_en_i`=1, `shutdown_o` stays high for (`hic_code_i`+1)×STEP_CLKS cycles. Each step of STEP_CLKS cycles stands for 4 ms.
- R8: With `resp_hiccup_i`=1 and `hic_prog_en_i`=0, the hiccup wait is DEFAULT_STEPS×STEP_CLKS cycles, which is 16 ms at the default of 4 steps.
- R9: When the hiccup wait ends, `restart_o` is high for exactly one cycle, in the first cycle that `shutdown_o` is low. The consecutive count is zero at that point, so a further 30 overcurrent intervals do not trip.
- R10: `fault_o` goes high on a trip and stays high through a restart. Only a `clear_faults_i` pulse or `enable_i` low clears it.
- R11: `limit_code_o` always equals `limit_code_i`.
- R12: After reset, `hs_en_o` is high (with `enable_i` high), and `shutdown_o`, `restart_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Converter enable; low clears a latched trip and the fault flag |
| ls_on_i | input | 1 | High while the low-side switch conducts |
| oc_flag_i | input | 1 | Valley-overcurrent comparator output |
| uv_flag_i | input | 1 | Output undervoltage flag |
| resp_hiccup_i | input | 1 | Trip response: 0 latch off, 1 hiccup retry |
| hic_prog_en_i | input | 1 | 1 uses the programmed hiccup wait, 0 uses the fixed wait |
| hic_code_i | input | 6 | Programmed hiccup wait, (code+1) steps of 4 ms |
| clear_faults_i | input | 1 | Pulse that clears the sticky fault flag |
| limit_code_i | input | 5 | Valley current limit, 1.5 A per LSB |
| limit_code_o | output | 5 | Limit code forwarded to the comparator |
| hs_en_o | output | 1 | High-side turn-on permitted |
| shutdown_o | output | 1 | Converter held off by the protection |
| restart_o | output | 1 | One-cycle request to start the converter again |
| fault_o | output | 1 | Sticky trip flag |

## Verification
The hardest states to reach are the edges of the consecutive-count window. One is the 31st overcurrent interval after a clean interval has wiped a run of 30. The other is a run of 30 that starts right after a hiccup restart. To reach them, a task drives whole low-side intervals, and each interval is placed so that it lands at the moment of the count being tested. The hiccup tests check the wait length exactly. They use a short step parameter and count the cycles for which `shutdown_o` stays high, up to the cycle in which `restart_o` appears.

// File: rtl/valley_ocp_pkg.sv
package valley_ocp_pkg;

    typedef enum logic [1:0] {
        PROT_RUN     = 2'd0,
        PROT_HICCUP  = 2'd1,
        PROT_LATCHED = 2'd2
    } prot_state_t;

endpackage

// File: rtl/ocp_interval_eval.sv
module ocp_interval_eval (
    input  logic clk,
    input  logic rst_n,
    input  logic ls_on_i,
    input  logic oc_flag_i,
    output logic done_o,
    output logic oc_seen_o
);
    typedef struct packed {
        logic ls;
        logic acc;
    } eval_regs_t;

    eval_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.ls  = ls_on_i;
        r_d.acc = ls_on_i & (r_q.acc | oc_flag_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o    = r_q.ls & ~ls_on_i;
    assign oc_seen_o = r_q.acc;
endmodule

// File: rtl/ocp_hiccup_timer.sv
module ocp_hiccup_timer #(
    parameter int STEP_CLKS = 400000,
    parameter int STEPS_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               abort_i,
    input  logic [STEPS_W-1:0] steps_i,
    output logic               expire_o
);
    localparam int PRE_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CLKS - 1);

    typedef struct packed {
        logic               active;
        logic [PRE_W-1:0]   pre;
        logic [STEPS_W-1:0] steps;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;
    logic      tick;

    always_comb begin
        r_d      = r_q;
        tick     = r_q.active && (r_q.pre == PRE_LAST);
        expire_o = tick && (r_q.steps == STEPS_W'(1));
        if (abort_i) begin
            r_d.active = 1'b0;
            r_d.pre    = '0;
        end else if (start_i) begin
            r_d.active = 1'b1;
            r_d.pre    = '0;
            r_d.steps  = steps_i;
        end else if (r_q.active) begin
            if (tick) begin
                r_d.pre   = '0;
                r_d.steps = r_q.steps - STEPS_W'(1);
                if (expire_o) r_d.active = 1'b0;
            end else begin
                r_d.pre = r_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/valley_ocp_ctrl.sv
module valley_ocp_ctrl
    import valley_ocp_pkg::*;
#(
    parameter int OC_TRIP_COUNT = 31,
    parameter int CODE_W        = 6,
    parameter int LIMIT_W       = 5,
    parameter int STEP_CLKS     = 400000,
    parameter int DEFAULT_STEPS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic               ls_on_i,
    input  logic               oc_flag_i,
    input  logic               uv_flag_i,
    input  logic               resp_hiccup_i,
    input  logic               hic_prog_en_i,
    input  logic [CODE_W-1:0]  hic_code_i,
    input  logic               clear_faults_i,
    input  logic [LIMIT_W-1:0] limit_code_i,
    output logic [LIMIT_W-1:0] limit_code_o,
    output logic               hs_en_o,
    output logic               shutdown_o,
    output logic               restart_o,
    output logic               fault_o
);
    localparam int CNT_W   = $clog2(OC_TRIP_COUNT + 1);
    localparam int STEPS_W = CODE_W + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OC_TRIP_COUNT - 1);

    typedef struct packed {
        prot_state_t      state;
        logic [CNT_W-1:0] cnt;
        logic             hs_ok;
        logic             restart;
        logic             fault;
        logic             en;
    } ctrl_regs_t;

    ctrl_regs_t         r_d, r_q;
    logic               iv_done, iv_oc;
    logic               trip, tmr_start, tmr_expire;
    logic [STEPS_W-1:0] hic_steps;

    ocp_interval_eval u_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .ls_on_i   (ls_on_i),
        .oc_flag_i (oc_flag_i),
        .done_o    (iv_done),
        .oc_seen_o (iv_oc)
    );

    assign hic_steps = hic_prog_en_i ? ({1'b0, hic_code_i} + STEPS_W'(1))
                                     : STEPS_W'(DEFAULT_STEPS);

    ocp_hiccup_timer #(
        .STEP_CLKS (STEP_CLKS),
        .STEPS_W   (STEPS_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tmr_start),
        .abort_i  (~enable_i),
        .steps_i  (hic_steps),
        .expire_o (tmr_expire)
    );

    always_comb begin
        r_d         = r_q;
        r_d.en      = enable_i;
        r_d.restart = 1'b0;
        trip        = 1'b0;
        tmr_start   = 1'b0;

        if (clear_faults_i) r_d.fault = 1'b0;

        if (!enable_i) begin
            r_d.state = PROT_RUN;
            r_d.cnt   = '0;
            r_d.hs_ok = 1'b1;
            r_d.fault = 1'b0;
        end else begin
            unique case (r_q.state)
                PROT_RUN: begin
                    if (iv_done) begin
                        if (iv_oc) begin
                            r_d.hs_ok = 1'b0;
                            r_d.cnt   = r_q.cnt + CNT_W'(1);
                            trip      = uv_flag_i || (r_q.cnt == CNT_LAST);
                        end else begin
                            r_d.hs_ok = 1'b1;
                            r_d.cnt   = '0;
                        end
                    end
                    if (trip) begin
                        r_d.fault = 1'b1;
                        r_d.cnt   = '0;
                        if (resp_hiccup_i) begin
                            r_d.state = PROT_HICCUP;
                            tmr_start = 1'b1;
                        end else begin
                            r_d.state = PROT_LATCHED;
                        end
                    end
                end
                PROT_HICCUP: begin
                    if (tmr_expire) begin
                        r_d.state   = PROT_RUN;
                        r_d.cnt     = '0;
                        r_d.hs_ok   = 1'b1;
                        r_d.restart = 1'b1;
                    end
                end
                default: r_d.state = PROT_LATCHED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= PROT_RUN;
            r_q.hs_ok <= 1'b1;
            r_q.en    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign shutdown_o   = (r_q.state != PROT_RUN);
    assign hs_en_o      = r_q.hs_ok && r_q.en && (r_q.state == PROT_RUN);
    assign restart_o    = r_q.restart;
    assign fault_o      = r_q.fault;
    assign limit_code_o = limit_code_i;
endmodule

// File: rtl/valley_ocp_checker.sv
module valley_ocp_checker (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic hs_en_o,
    input logic shutdown_o,
    input logic restart_o,
    input logic fault_o
);
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o); // R9

    AST_RESTART_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> ($past(shutdown_o) && !shutdown_o)); // R9

    AST_TRIP_FLAGS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_o) |-> fault_o); // R10

    AST_NO_HS_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> !hs_en_o); // R5

    AST_DISABLE_BLOCKS_HS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!hs_en_o && !shutdown_o && !fault_o)); // R6
endmodule

bind valley_ocp_ctrl valley_ocp_checker u_valley_ocp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .hs_en_o    (hs_en_o),
    .shutdown_o (shutdown_o),
    .restart_o  (restart_o),
    .fault_o    (fault_o)
);

// File: tb/valley_ocp_ctrl_bench.sv
module valley_ocp_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 8;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b1;
    logic       ls_on_i = 1'b0;
    logic       oc_flag_i = 1'b0;
    logic       uv_flag_i = 1'b0;
    logic       resp_hiccup_i = 1'b1;
    logic       hic_prog_en_i = 1'b0;
    logic [5:0] hic_code_i = '0;
    logic       clear_faults_i = 1'b0;
    logic [4:0] limit_code_i = 5'b10100;
    logic [4:0] limit_code_o;
    logic       hs_en_o, shutdown_o, restart_o, fault_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    valley_ocp_ctrl #(.STEP_CLKS(STEP)) u_valley_ocp_ctrl (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .ls_on_i(ls_on_i),
        .oc_flag_i(oc_flag_i), .uv_flag_i(uv_flag_i),
        .resp_hiccup_i(resp_hiccup_i), .hic_prog_en_i(hic_prog_en_i),
        .hic_code_i(hic_code_i), .clear_faults_i(clear_faults_i),
        .limit_code_i(limit_code_i), .limit_code_o(limit_code_o),
        .hs_en_o(hs_en_o), .shutdown_o(shutdown_o), .restart_o(restart_o),
        .fault_o(fault_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one low-side interval; returns at the negedge after the evaluating edge
    task automatic ls_cycle(input logic oc, input logic uv);
        ls_on_i = 1'b1; oc_flag_i = oc; uv_flag_i = 1'b0;
        @(negedge clk);
        oc_flag_i = 1'b0;
        @(negedge clk);
        ls_on_i = 1'b0; uv_flag_i = uv;
        @(negedge clk);
        uv_flag_i = 1'b0;
    endtask

    task automatic oc_run(input int n);
        for (int i = 0; i < n; i++) ls_cycle(1'b1, 1'b0);
    endtask

    // called in the first cycle shutdown_o is high; returns shutdown length
    task automatic wait_out(output int len, output int rs);
        len = 0;
        while (shutdown_o && len < 2000) begin
            len++;
            @(negedge clk);
        end
        rs = restart_o;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R12 hs_en", hs_en_o, 1);
        chk("R12 shutdown", shutdown_o, 0);
        chk("R12 restart", restart_o, 0);
        chk("R12 fault", fault_o, 0);
    endtask

    task automatic t_gate;
        ls_cycle(1'b1, 1'b0);
        chk("R1 hs blocked after oc interval", hs_en_o, 0);
        ls_cycle(1'b0, 1'b0);
        chk("R1 hs allowed after clean interval", hs_en_o, 1);
    endtask

    task automatic t_limit;
        limit_code_i = 5'b10100; #1;
        chk("R11 limit pass 30A", limit_code_o, 20);
        limit_code_i = 5'b00011; #1;
        chk("R11 limit pass 3", limit_code_o, 3);
        limit_code_i = 5'b10100;
    endtask

    task automatic t_clean_resets;
        oc_run(30);
        ls_cycle(1'b0, 1'b0);
        oc_run(30);
        chk("R3 clean interval clears count", shutdown_o, 0);
        ls_cycle(1'b0, 1'b0);
    endtask

    task automatic t_count_default_hiccup;
        int len, rs;
        resp_hiccup_i = 1'b1; hic_prog_en_i = 1'b0;
        oc_run(30);
        chk("R2 no trip at 30", shutdown_o, 0);
        ls_cycle(1'b1, 1'b0);
        chk("R2 trip at 31", shutdown_o, 1);
        chk("R10 fault set on trip", fault_o, 1);
        wait_out(len, rs);
        chk("R8 default hiccup length", len, 4 * STEP);
        chk("R9 restart pulse", rs, 1);
        chk("R9 restart one cycle", restart_o, 0);
        chk("R10 fault sticky after restart", fault_o, 1);
        oc_run(30);
        chk("R9 count cleared after restart", shutdown_o, 0);
        ls_cycle(1'b0, 1'b0);
        clear_faults_i = 1'b1; @(negedge clk); clear_faults_i = 1'b0;
        chk("R10 clear faults", fault_o, 0);
    endtask

    task automatic t_prog_hiccup(input logic [5:0] code);
        int len, rs;
        resp_hiccup_i = 1'b1; hic_prog_en_i = 1'b1; hic_code_i = code;
        oc_run(31);
        chk("R7 trip", shutdown_o, 1);
        wait_out(len, rs);
        chk("R7 programmed hiccup length", len, (code + 1) * STEP);
        chk("R9 restart at end of programmed wait", rs, 1);
        ls_cycle(1'b0, 1'b0);
    endtask

    task automatic t_uv;
        int len, rs;
        hic_prog_en_i = 1'b1; hic_code_i = 6'd0;
        ls_cycle(1'b0, 1'b1);
        chk("R4 uv with clean interval no trip", shutdown_o, 0);
        ls_cycle(1'b1, 1'b1);
        chk("R4 uv with oc trips at once", shutdown_o, 1);
        wait_out(len, rs);
        chk("R4 uv trip hiccup length", len, STEP);
        ls_cycle(1'b0, 1'b0);
    endtask

    task automatic t_latch;
        resp_hiccup_i = 1'b0;
        oc_run(31);
        chk("R5 latched shutdown", shutdown_o, 1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (restart_o) chk("R5 no restart when latched", 1, 0);
        end
        ls_cycle(1'b0, 1'b0);
        ls_cycle(1'b0, 1'b0);
        chk("R5 still shut after clean intervals", shutdown_o, 1);
        chk("R5 hs blocked when latched", hs_en_o, 0);
        clear_faults_i = 1'b1; @(negedge clk); clear_faults_i = 1'b0;
        chk("R6 clear faults does not release latch", shutdown_o, 1);
        enable_i = 1'b0;
        @(negedge clk);
        chk("R6 hs off while disabled", hs_en_o, 0);
        chk("R10 disable clears fault", fault_o, 0);
        enable_i = 1'b1;
        @(negedge clk);
        chk("R6 latch released", shutdown_o, 0);
        chk("R6 hs back on", hs_en_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_limit();
        t_clean_resets();
        t_count_default_hiccup();
        t_prog_hiccup(6'd2);
        t_prog_hiccup(6'd0);
        t_uv();
        t_latch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule